// File: doc/BRIEF.md
# Working-Descriptor Translation Cache

This block is a small fully associative store that sits beside an address-translation unit and keeps recently built working descriptors. Each working descriptor merges what a segment descriptor and a page descriptor say about one page of one segment: where the page sits in physical memory and which kinds of access are allowed. A requester presents a segment number and a page number and, in the same cycle, learns whether the pair is held, along with the physical page base and the merged access rights.

When a lookup misses, the external table walk builds a fresh descriptor and hands it to the insert port, together with the separate segment-level and page-level rights. The block merges them with a bitwise AND, so a page can only narrow what its segment allows. Every insert is stored. An insert whose key is already held rewrites that entry in place. When every slot is occupied, the slot that has held its descriptor longest is overwritten, and the slots form a ring in insertion order. A command port serves supervisor software. It can wipe the store, read back any chosen slot, or read back the oldest slot so that page usage can be measured. Commands issued while the processor runs in slave mode are refused and raise a fault flag.

Top module: `descriptor_cache`

## Requirements
- R1: With `lookupValid` high, `lookupHit` is 1 in the same cycle exactly when a valid entry holds the presented segment and page. On a hit `lookupBase` and `lookupPerm` carry that entry's base and merged rights. Otherwise all three outputs are 0, and they are also 0 when `lookupValid` is low.
- R2: The stored rights are `insertSegPerm & insertPagePerm`, with bit 0 read, bit 1 write and bit 2 execute. After a clear or reset, inserts of new keys fill slots 0, 1, 2 and so on in order.
- R3: An insert of a new key into a full store overwrites the oldest slot, and the oldest position then advances by one, wrapping from the last slot to slot 0. Entries disappear only through a clear.
- R4: An insert whose key matches a valid entry rewrites that entry's base and rights. It takes no new slot and does not change the entry's age. A lookup of the same key in that cycle still returns the old contents.
- R5: `cmdOp` = 1 (clear), when accepted, invalidates every entry at the clock edge. An insert in the same cycle is discarded, and the next new key goes to slot 0.
- R6: `cmdOp` = 2 (read selected), when accepted, sets `rdValid` for one cycle in the next cycle. `rdIndex` then equals `cmdIndex`, and `rdEntryValid`, `rdSeg`, `rdPage`, `rdBase` and `rdPerm` show that slot as it was before the edge.
- R7: `cmdOp` = 3 (read oldest), when accepted, returns the oldest slot in the same way, with its index on `rdIndex`. On an empty store it returns index 0 with `rdEntryValid` 0.
- R8: A command with `cmdValid` and `slaveMode` both high sets `privFault` for one cycle in the next cycle. It produces no `rdValid` and leaves the store unchanged. `cmdOp` = 0 does nothing.
- R9: After reset every entry is invalid and `lookupHit`, `rdValid` and `privFault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveMode | input | 1 | High when the processor runs unprivileged |
| lookupValid | input | 1 | Lookup request |
| lookupSeg | input | 18 | Segment number to look up |
| lookupPage | input | 8 | Page number to look up |
| lookupHit | output | 1 | Key present (same cycle) |
| lookupBase | output | 18 | Physical page base on hit |
| lookupPerm | output | 3 | Merged rights on hit |
| insertValid | input | 1 | Insert a working descriptor |
| insertSeg | input | 18 | Segment number of the new descriptor |
| insertPage | input | 8 | Page number of the new descriptor |
| insertBase | input | 18 | Physical page base |
| insertSegPerm | input | 3 | Segment-level rights |
| insertPagePerm | input | 3 | Page-level rights |
| cmdValid | input | 1 | Supervisor command strobe |
| cmdOp | input | 2 | 0 none, 1 clear, 2 read selected, 3 read oldest |
| cmdIndex | input | 4 | Slot for read selected |
| rdValid | output | 1 | Readout valid |
| rdEntryValid | output | 1 | Read slot holds a descriptor |
| rdIndex | output | 4 | Slot that was read |
| rdSeg | output | 18 | Segment number of read slot |
| rdPage | output | 8 | Page number of read slot |
| rdBase | output | 18 | Page base of read slot |
| rdPerm | output | 3 | Merged rights of read slot |
| privFault | output | 1 | Command refused in slave mode |

## Verification
The assertions check several rules on every cycle. A refused command yields a fault and no readout. Accepted reads answer one cycle later with the requested index. A lookup after a clear always misses. A miss drives zero data. The count of valid entries never falls except after a clear. Other behaviours can only be shown by the bench's scenarios against its reference model: which slot is evicted, where the oldest position sits after wrapping, in-place rewrite of a held key without a change of age, and the AND of the two rights fields.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

  typedef enum logic [1:0] {
    CMD_NOP         = 2'd0,
    CMD_CLEAR       = 2'd1,
    CMD_READ_SEL    = 2'd2,
    CMD_READ_OLDEST = 2'd3
  } cmdOpE;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic writeEn;
    logic readEn;
  } strobeS;

endpackage

// File: rtl/wdc_control.sv
module wdc_control
  import wdc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slaveMode,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdIndex,
  input  logic             insertValid,
  input  logic             insertHit,
  input  logic [IDX_W-1:0] insertHitIdx,
  output strobeS           strobe,
  output logic [IDX_W-1:0] writeIdx,
  output logic [IDX_W-1:0] readIdx,
  output logic             privFault
);

  logic [IDX_W-1:0] headPtr;
  logic [CNT_W-1:0] fillCount;
  logic             cmdAccepted;
  logic             storeFull;
  cmdOpE            op;

  assign op          = cmdOpE'(cmdOp);
  assign cmdAccepted = cmdValid && !slaveMode;
  assign storeFull   = (fillCount == CNT_W'(DEPTH));

  always_comb begin
    strobe.clearAll = cmdAccepted && (op == CMD_CLEAR);
    strobe.readEn   = cmdAccepted && ((op == CMD_READ_SEL) || (op == CMD_READ_OLDEST));
    strobe.writeEn  = insertValid && !strobe.clearAll;
    readIdx         = (op == CMD_READ_SEL) ? cmdIndex : headPtr;
    if (insertHit)      writeIdx = insertHitIdx;
    else if (storeFull) writeIdx = headPtr;
    else                writeIdx = headPtr + fillCount[IDX_W-1:0];
  end

  // Ring of slots in insertion order
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      fillCount <= '0;
    end else if (strobe.clearAll) begin
      headPtr   <= '0;
      fillCount <= '0;
    end else if (strobe.writeEn && !insertHit) begin
      if (storeFull) headPtr   <= headPtr + 1'b1;
      else           fillCount <= fillCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= cmdValid && slaveMode;
  end

endmodule

// File: rtl/wdc_datapath.sv
module wdc_datapath
  import wdc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SEG_W  = 18,
  parameter int PAGE_W = 8,
  parameter int BASE_W = 18,
  parameter int PERM_W = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            strobe,
  input  logic [IDX_W-1:0]  writeIdx,
  input  logic [IDX_W-1:0]  readIdx,
  input  logic              lookupValid,
  input  logic [SEG_W-1:0]  lookupSeg,
  input  logic [PAGE_W-1:0] lookupPage,
  output logic              lookupHit,
  output logic [BASE_W-1:0] lookupBase,
  output logic [PERM_W-1:0] lookupPerm,
  input  logic [SEG_W-1:0]  insertSeg,
  input  logic [PAGE_W-1:0] insertPage,
  input  logic [BASE_W-1:0] insertBase,
  input  logic [PERM_W-1:0] insertSegPerm,
  input  logic [PERM_W-1:0] insertPagePerm,
  output logic              insertHit,
  output logic [IDX_W-1:0]  insertHitIdx,
  output logic [DEPTH-1:0]  validVec,
  output logic              rdValid,
  output logic              rdEntryValid,
  output logic [IDX_W-1:0]  rdIndex,
  output logic [SEG_W-1:0]  rdSeg,
  output logic [PAGE_W-1:0] rdPage,
  output logic [BASE_W-1:0] rdBase,
  output logic [PERM_W-1:0] rdPerm
);

  logic [SEG_W-1:0]  segArr  [DEPTH];
  logic [PAGE_W-1:0] pageArr [DEPTH];
  logic [BASE_W-1:0] baseArr [DEPTH];
  logic [PERM_W-1:0] permArr [DEPTH];
  logic [DEPTH-1:0]  lookupMatch;
  logic [DEPTH-1:0]  insertMatch;
  logic [PERM_W-1:0] mergedPerm;

  assign mergedPerm = insertSegPerm & insertPagePerm;

  for (genvar g = 0; g < DEPTH; g++) begin : gCompare
    assign lookupMatch[g] = validVec[g] && (segArr[g] == lookupSeg) && (pageArr[g] == lookupPage);
    assign insertMatch[g] = validVec[g] && (segArr[g] == insertSeg) && (pageArr[g] == insertPage);
  end

  // Keys are unique, so an OR across masked entries selects the hit
  always_comb begin
    lookupHit  = 1'b0;
    lookupBase = '0;
    lookupPerm = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lookupValid && lookupMatch[i]) begin
        lookupHit  = 1'b1;
        lookupBase = lookupBase | baseArr[i];
        lookupPerm = lookupPerm | permArr[i];
      end
    end
  end

  always_comb begin
    insertHit    = |insertMatch;
    insertHitIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (insertMatch[i]) insertHitIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 validVec <= '0;
    else if (strobe.clearAll)  validVec <= '0;
    else if (strobe.writeEn)   validVec[writeIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.writeEn) begin
      segArr[writeIdx]  <= insertSeg;
      pageArr[writeIdx] <= insertPage;
      baseArr[writeIdx] <= insertBase;
      permArr[writeIdx] <= mergedPerm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid      <= 1'b0;
      rdEntryValid <= 1'b0;
      rdIndex      <= '0;
      rdSeg        <= '0;
      rdPage       <= '0;
      rdBase       <= '0;
      rdPerm       <= '0;
    end else begin
      rdValid <= strobe.readEn;
      if (strobe.readEn) begin
        rdEntryValid <= validVec[readIdx];
        rdIndex      <= readIdx;
        rdSeg        <= segArr[readIdx];
        rdPage       <= pageArr[readIdx];
        rdBase       <= baseArr[readIdx];
        rdPerm       <= permArr[readIdx];
      end
    end
  end

endmodule

// File: rtl/descriptor_cache.sv
module descriptor_cache
  import wdc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SEG_W  = 18,
  parameter int PAGE_W = 8,
  parameter int BASE_W = 18,
  parameter int PERM_W = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              lookupValid,
  input  logic [SEG_W-1:0]  lookupSeg,
  input  logic [PAGE_W-1:0] lookupPage,
  output logic              lookupHit,
  output logic [BASE_W-1:0] lookupBase,
  output logic [PERM_W-1:0] lookupPerm,
  input  logic              insertValid,
  input  logic [SEG_W-1:0]  insertSeg,
  input  logic [PAGE_W-1:0] insertPage,
  input  logic [BASE_W-1:0] insertBase,
  input  logic [PERM_W-1:0] insertSegPerm,
  input  logic [PERM_W-1:0] insertPagePerm,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [IDX_W-1:0]  cmdIndex,
  output logic              rdValid,
  output logic              rdEntryValid,
  output logic [IDX_W-1:0]  rdIndex,
  output logic [SEG_W-1:0]  rdSeg,
  output logic [PAGE_W-1:0] rdPage,
  output logic [BASE_W-1:0] rdBase,
  output logic [PERM_W-1:0] rdPerm,
  output logic              privFault
);

  strobeS           strobe;
  logic [IDX_W-1:0] writeIdx;
  logic [IDX_W-1:0] readIdx;
  logic             insertHit;
  logic [IDX_W-1:0] insertHitIdx;
  logic [DEPTH-1:0] validVec;

  wdc_control #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIndex(cmdIndex),
    .insertValid(insertValid), .insertHit(insertHit), .insertHitIdx(insertHitIdx),
    .strobe(strobe), .writeIdx(writeIdx), .readIdx(readIdx), .privFault(privFault)
  );

  wdc_datapath #(
    .DEPTH(DEPTH), .SEG_W(SEG_W), .PAGE_W(PAGE_W), .BASE_W(BASE_W), .PERM_W(PERM_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .writeIdx(writeIdx), .readIdx(readIdx),
    .lookupValid(lookupValid), .lookupSeg(lookupSeg), .lookupPage(lookupPage),
    .lookupHit(lookupHit), .lookupBase(lookupBase), .lookupPerm(lookupPerm),
    .insertSeg(insertSeg), .insertPage(insertPage), .insertBase(insertBase),
    .insertSegPerm(insertSegPerm), .insertPagePerm(insertPagePerm),
    .insertHit(insertHit), .insertHitIdx(insertHitIdx), .validVec(validVec),
    .rdValid(rdValid), .rdEntryValid(rdEntryValid), .rdIndex(rdIndex),
    .rdSeg(rdSeg), .rdPage(rdPage), .rdBase(rdBase), .rdPerm(rdPerm)
  );

endmodule

// File: rtl/descriptor_cache_checker.sv
module descriptor_cache_checker #(
  parameter int DEPTH  = 16,
  parameter int BASE_W = 18,
  parameter int PERM_W = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              slaveMode,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [IDX_W-1:0]  cmdIndex,
  input logic              lookupHit,
  input logic [BASE_W-1:0] lookupBase,
  input logic [PERM_W-1:0] lookupPerm,
  input logic              rdValid,
  input logic [IDX_W-1:0]  rdIndex,
  input logic              privFault,
  input logic [DEPTH-1:0]  validVec
);

  logic clearTaken;
  assign clearTaken = cmdValid && !slaveMode && (cmdOp == 2'd1);

  assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> (lookupBase == '0) && (lookupPerm == '0));

  assert_no_loss_R3: assert property (@(posedge clk) disable iff (!rstN)
    !clearTaken |=> ($countones(validVec) >= $past($countones(validVec))));

  assert_clear_misses_R5: assert property (@(posedge clk) disable iff (!rstN)
    clearTaken |=> !lookupHit);

  assert_read_sel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !slaveMode && cmdOp == 2'd2) |=> rdValid && (rdIndex == $past(cmdIndex)));

  assert_slave_fault_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && slaveMode) |=> privFault && !rdValid);

  assert_no_spurious_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && !slaveMode && cmdOp[1]) |=> !rdValid);

endmodule

bind descriptor_cache descriptor_cache_checker #(
  .DEPTH(DEPTH), .BASE_W(BASE_W), .PERM_W(PERM_W)
) chk_i (
  .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .cmdValid(cmdValid),
  .cmdOp(cmdOp), .cmdIndex(cmdIndex), .lookupHit(lookupHit),
  .lookupBase(lookupBase), .lookupPerm(lookupPerm), .rdValid(rdValid),
  .rdIndex(rdIndex), .privFault(privFault), .validVec(validVec)
);

// File: tb/descriptor_cache_tb_top.sv
module descriptor_cache_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        slaveMode;
  logic        lookupValid;
  logic [17:0] lookupSeg;
  logic [7:0]  lookupPage;
  logic        lookupHit;
  logic [17:0] lookupBase;
  logic [2:0]  lookupPerm;
  logic        insertValid;
  logic [17:0] insertSeg;
  logic [7:0]  insertPage;
  logic [17:0] insertBase;
  logic [2:0]  insertSegPerm;
  logic [2:0]  insertPagePerm;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [3:0]  cmdIndex;
  logic        rdValid;
  logic        rdEntryValid;
  logic [3:0]  rdIndex;
  logic [17:0] rdSeg;
  logic [7:0]  rdPage;
  logic [17:0] rdBase;
  logic [2:0]  rdPerm;
  logic        privFault;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  bit mValid [DEPTH];
  int mSeg   [DEPTH];
  int mPage  [DEPTH];
  int mBase  [DEPTH];
  int mPerm  [DEPTH];
  int mHead  = 0;
  int mCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  descriptor_cache dut_i (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .lookupValid(lookupValid), .lookupSeg(lookupSeg), .lookupPage(lookupPage),
    .lookupHit(lookupHit), .lookupBase(lookupBase), .lookupPerm(lookupPerm),
    .insertValid(insertValid), .insertSeg(insertSeg), .insertPage(insertPage),
    .insertBase(insertBase), .insertSegPerm(insertSegPerm), .insertPagePerm(insertPagePerm),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIndex(cmdIndex),
    .rdValid(rdValid), .rdEntryValid(rdEntryValid), .rdIndex(rdIndex),
    .rdSeg(rdSeg), .rdPage(rdPage), .rdBase(rdBase), .rdPerm(rdPerm),
    .privFault(privFault)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int k = 0; k < DEPTH; k++) mValid[k] = 0;
    mHead = 0;
    mCount = 0;
  endtask

  // One cycle: drive at negedge, check combinational outputs, advance, check registered outputs
  task automatic step(input string req,
                      input bit lv, input int ls, input int lp,
                      input bit iv, input int is, input int ip, input int ib, input int isp, input int ipp,
                      input bit cv, input bit sm, input int op, input int ci);
    bit expHit; int expBase; int expPerm;
    bit acc; bit expRd; int idx; bit expFault; int hitIdx;
    lookupValid = lv; lookupSeg = 18'(ls); lookupPage = 8'(lp);
    insertValid = iv; insertSeg = 18'(is); insertPage = 8'(ip); insertBase = 18'(ib);
    insertSegPerm = 3'(isp); insertPagePerm = 3'(ipp);
    cmdValid = cv; slaveMode = sm; cmdOp = 2'(op); cmdIndex = 4'(ci);
    #1;
    expHit = 0; expBase = 0; expPerm = 0;
    if (lv) for (int k = 0; k < DEPTH; k++)
      if (mValid[k] && mSeg[k] == ls && mPage[k] == lp) begin
        expHit = 1; expBase = mBase[k]; expPerm = mPerm[k];
      end
    check(req, "lookup", {lookupHit, lookupBase, lookupPerm},
          {expHit, 18'(expBase), 3'(expPerm)});
    acc = cv && !sm;
    expRd = acc && (op == 2 || op == 3);
    idx = (op == 2) ? ci : mHead;
    expFault = cv && sm;
    begin
      bit   pv = mValid[idx];
      int   ps = mSeg[idx], pp = mPage[idx], pb = mBase[idx], pr = mPerm[idx];
      // model update at the edge
      if (acc && op == 1) modelClear();
      else if (iv) begin
        hitIdx = -1;
        for (int k = 0; k < DEPTH; k++)
          if (mValid[k] && mSeg[k] == is && mPage[k] == ip) hitIdx = k;
        if (hitIdx < 0) begin
          if (mCount < DEPTH) begin hitIdx = (mHead + mCount) % DEPTH; mCount++; end
          else begin hitIdx = mHead; mHead = (mHead + 1) % DEPTH; end
        end
        mValid[hitIdx] = 1; mSeg[hitIdx] = is; mPage[hitIdx] = ip;
        mBase[hitIdx] = ib; mPerm[hitIdx] = isp & ipp;
      end
      @(posedge clk);
      @(negedge clk);
      check(req, "rdValid/privFault", {rdValid, privFault}, {expRd, expFault});
      if (expRd && rdValid) begin
        check(req, "rdIndex/rdEntryValid", {rdIndex, rdEntryValid}, {4'(idx), pv});
        if (pv) check(req, "rd fields", {rdSeg, rdPage, rdBase, rdPerm},
                      {18'(ps), 8'(pp), 18'(pb), 3'(pr)});
      end
    end
  endtask

  task automatic doInsert(input string req, input int s, input int p, input int b, input int sp, input int pp);
    step(req, 0, 0, 0, 1, s, p, b, sp, pp, 0, 0, 0, 0);
  endtask

  task automatic doLookup(input string req, input int s, input int p);
    step(req, 1, s, p, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doCmd(input string req, input bit sm, input int op, input int ci);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, sm, op, ci);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    modelClear();
    lookupValid = 1; lookupSeg = 18'd5; lookupPage = 8'd1;
    @(negedge clk); #1;
    // R9: reset state
    check("R9", "reset outputs", {lookupHit, rdValid, privFault}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);

    doCmd("R7", 0, 3, 0);                       // oldest on empty store
    doInsert("R2", 5, 1, 'h100, 3'b111, 3'b011);
    doInsert("R2", 5, 2, 'h200, 3'b101, 3'b111);
    doInsert("R2", 7, 9, 'h300, 3'b110, 3'b010);
    doLookup("R1", 5, 1);
    doLookup("R1", 7, 9);
    doLookup("R1", 5, 3);                      // miss
    step("R1", 0, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); // lookupValid low
    // R4: rewrite held key while looking it up
    step("R4", 1, 5, 1, 1, 5, 1, 'h1AB, 3'b100, 3'b111, 0, 0, 0, 0);
    doLookup("R4", 5, 1);
    doCmd("R4", 0, 2, 0);
    doCmd("R4", 0, 2, 3);                      // slot 3 still empty
    doCmd("R6", 0, 2, 1);
    doCmd("R6", 0, 2, 2);
    // R8: refused commands
    doCmd("R8", 1, 2, 0);
    doCmd("R8", 1, 1, 0);
    doLookup("R8", 5, 1);
    doCmd("R8", 0, 0, 0);
    // R3: fill then evict
    for (int k = 0; k < 13; k++) doInsert("R3", 100 + k, k, 'h400 + k, 3'b111, 3'b101);
    doCmd("R7", 0, 3, 0);
    doInsert("R3", 200, 1, 'h500, 3'b011, 3'b011);
    doInsert("R3", 201, 2, 'h501, 3'b111, 3'b111);
    doLookup("R3", 5, 1);
    doLookup("R3", 5, 2);
    doLookup("R3", 7, 9);
    doCmd("R7", 0, 3, 0);
    doCmd("R6", 0, 2, 0);
    for (int k = 0; k < 15; k++) doInsert("R3", 300 + k, k, 'h600 + k, 3'b001, 3'b111);
    doCmd("R7", 0, 3, 0);
    doLookup("R3", 201, 2);
    // R5: clear with simultaneous insert
    step("R5", 0, 0, 0, 1, 9, 9, 'h777, 3'b111, 3'b111, 1, 0, 1, 0);
    doLookup("R5", 9, 9);
    doLookup("R5", 314, 14);
    doCmd("R7", 0, 3, 0);
    doInsert("R5", 11, 4, 'h0AA, 3'b111, 3'b110);
    doCmd("R5", 0, 2, 0);
    doLookup("R2", 11, 4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule